// File: doc/BRIEF.md
# Per-Trace Speculative Store Buffer

This block holds the memory writes of speculatively executing traces until each trace is resolved. Every trace context has a private queue. A store from a context lands in that context's queue and never reaches memory directly. A load from a context is looked up in that context's own queue only. Matching buffered bytes are merged over the word read from memory, and the youngest store wins per byte. The load result is registered and appears one cycle later.

When a context is confirmed correct, its queue drains to memory in program order through a valid/ready write port, one entry per handshake. A per-context busy flag stays high until the drain is finished. When a context is squashed, its queue is emptied without any write. Only one queue drains at a time, so write-port traffic never interleaves two traces.

Top module: `spec_store_buf`

## Requirements
- R1: The memory write port is valid only while at least one context is busy. A store never produces a memory write before its context is committed.
- R2: A load returns its data one cycle after it is presented, with `ld_rsp_valid` high in that cycle and low when no load was presented. Each byte lane whose enable was set by a buffered store of the same context at the same (word-aligned, fully compared) address takes the byte from the youngest such store.
- R3: A load never sees the buffered stores of any other context.
- R4: `mem_rd_en` is high exactly when a load is presented and its own buffer does not cover all four byte lanes. Uncovered lanes come from `mem_rd_data`, sampled in the cycle the load is presented.
- R5: A committed buffer is written to memory oldest entry first, one entry per cycle in which valid and ready are both high. Address, data and byte enables hold steady while valid waits for ready.
- R6: After a commit of a non-empty context, its `busy` bit is high from the next cycle until the edge at which its last entry is accepted. While busy, stores to that context raise `st_stall` and are not taken.
- R7: A discard empties the named context's buffer with no memory write. Later loads from that context return plain memory data.
- R8: Each buffer holds 8 entries. A store to a full buffer raises `st_stall`, and the rejected store has no effect on later loads.
- R9: A discard aimed at a context that is busy draining is ignored, and all of its entries still reach memory.
- R10: Reset clears all buffers and busy bits. After reset, the write port and load response are idle.
- R11: Once a buffer begins draining, it finishes before any other committed buffer issues a write. The waiting context keeps `busy` high meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request |
| st_ctx | input | CTXW | Issuing context of the store |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| st_stall | output | 1 | Store to `st_ctx` cannot be taken this cycle |
| ld_valid | input | 1 | Load request |
| ld_ctx | input | CTXW | Issuing context of the load |
| ld_addr | input | AW | Load word address |
| ld_rsp_valid | output | 1 | Registered load response valid |
| ld_rsp_data | output | DW | Registered merged load data |
| cmt_valid | input | 1 | Trace confirmed correct |
| cmt_ctx | input | CTXW | Context being committed |
| dis_valid | input | 1 | Trace mispredicted or flushed |
| dis_ctx | input | CTXW | Context being discarded |
| busy | output | NUM_CTX | Per-context drain in progress |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_data | output | DW | Memory write data |
| mem_wr_be | output | DW/8 | Memory write byte enables |
| mem_rd_en | output | 1 | Memory read request for a load |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | DW | Memory read data, same cycle |

## Verification
The bound checker watches, on every cycle, that writes appear only under a busy context and stay stable while stalled by ready. It also checks the fixed one-cycle load latency, that memory reads occur only for loads, and the post-reset idle state. Drain order, youngest-wins byte merging, isolation between contexts, the full-buffer stall and the ignored discard depend on what was stored earlier, so only the bench's sweeps can show them. Those sweeps compare every load against a byte-level model and every drained write against the recorded store order.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  localparam int unsigned BYTE_W = 8;

  function automatic int unsigned ctx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ssb_ctx_buf.sv
// One context's store queue: in-order storage, head read-out for draining,
// and a youngest-wins byte-lane search for load forwarding.
module ssb_ctx_buf
  import ssb_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  localparam int unsigned NB   = DW / BYTE_W,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic [NB-1:0] push_be,
  input  logic          pop,
  input  logic          clr,
  input  logic [AW-1:0] q_addr,
  output logic [DW-1:0] fwd_data,
  output logic [NB-1:0] fwd_mask,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic [NB-1:0] head_be,
  output logic          full,
  output logic          empty,
  output logic          single
);
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [NB-1:0] be_q   [DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] cnt;

  // Storage without reset so it can map to distributed RAM.
  always_ff @(posedge clk) begin
    if (push && !clr) begin
      addr_q[tail] <= push_addr;
      data_q[tail] <= push_data;
      be_q[tail]   <= push_be;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      if (push) tail <= tail + PW'(1);
      if (pop)  head <= head + PW'(1);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assign full      = (cnt == CW'(DEPTH));
  assign empty     = (cnt == '0);
  assign single    = (cnt == CW'(1));
  assign head_addr = addr_q[head];
  assign head_data = data_q[head];
  assign head_be   = be_q[head];

  // Walk oldest to youngest so later matches overwrite earlier lanes.
  always_comb begin
    fwd_data = '0;
    fwd_mask = '0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [PW-1:0] idx;
      idx = head + PW'(i);
      if ((CW'(i) < cnt) && (addr_q[idx] == q_addr)) begin
        for (int b = 0; b < NB; b++) begin
          if (be_q[idx][b]) begin
            fwd_data[b*BYTE_W +: BYTE_W] = data_q[idx][b*BYTE_W +: BYTE_W];
            fwd_mask[b] = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ssb_drain_ctl.sv
// Tracks which contexts are committed and locks the write port to one
// draining context until its queue is empty.
module ssb_drain_ctl
  import ssb_pkg::*;
#(
  parameter int unsigned NUM_CTX = 2,
  localparam int unsigned CTXW   = ctx_bits(NUM_CTX)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CTX-1:0] commit_hit,
  input  logic [NUM_CTX-1:0] empty,
  input  logic [NUM_CTX-1:0] single,
  input  logic [NUM_CTX-1:0] pop,
  output logic [NUM_CTX-1:0] busy,
  output logic [CTXW-1:0]    sel,
  output logic               active
);
  logic [NUM_CTX-1:0] busy_nxt;
  logic [CTXW-1:0]    own, pick;
  logic               own_v;

  always_comb begin
    pick = '0;
    for (int c = NUM_CTX - 1; c >= 0; c--) begin
      if (busy[c]) pick = CTXW'(c);
    end
  end

  assign sel    = own_v ? own : pick;
  assign active = own_v | (|busy);

  always_comb begin
    for (int c = 0; c < NUM_CTX; c++) begin
      busy_nxt[c] = commit_hit[c] |
                    (busy[c] & ~(empty[c] | (pop[c] & single[c])));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= '0;
      own   <= '0;
      own_v <= 1'b0;
    end else begin
      busy <= busy_nxt;
      if (own_v) begin
        own_v <= busy_nxt[own];
      end else if (|busy) begin
        own   <= pick;
        own_v <= busy_nxt[pick];
      end
    end
  end
endmodule

// File: rtl/spec_store_buf.sv
module spec_store_buf
  import ssb_pkg::*;
#(
  parameter int unsigned NUM_CTX = 2,
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned AW      = 32,
  parameter int unsigned DW      = 32,
  localparam int unsigned NB     = DW / BYTE_W,
  localparam int unsigned CTXW   = ctx_bits(NUM_CTX)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               st_valid,
  input  logic [CTXW-1:0]    st_ctx,
  input  logic [AW-1:0]      st_addr,
  input  logic [DW-1:0]      st_data,
  input  logic [NB-1:0]      st_be,
  output logic               st_stall,
  input  logic               ld_valid,
  input  logic [CTXW-1:0]    ld_ctx,
  input  logic [AW-1:0]      ld_addr,
  output logic               ld_rsp_valid,
  output logic [DW-1:0]      ld_rsp_data,
  input  logic               cmt_valid,
  input  logic [CTXW-1:0]    cmt_ctx,
  input  logic               dis_valid,
  input  logic [CTXW-1:0]    dis_ctx,
  output logic [NUM_CTX-1:0] busy,
  output logic               mem_wr_valid,
  input  logic               mem_wr_ready,
  output logic [AW-1:0]      mem_wr_addr,
  output logic [DW-1:0]      mem_wr_data,
  output logic [NB-1:0]      mem_wr_be,
  output logic               mem_rd_en,
  output logic [AW-1:0]      mem_rd_addr,
  input  logic [DW-1:0]      mem_rd_data
);
  logic [NUM_CTX-1:0] push, pop, clr, commit_hit;
  logic [NUM_CTX-1:0] full, empty, single;
  logic [AW-1:0]      hd_addr [NUM_CTX];
  logic [DW-1:0]      hd_data [NUM_CTX];
  logic [NB-1:0]      hd_be   [NUM_CTX];
  logic [DW-1:0]      fw_data [NUM_CTX];
  logic [NB-1:0]      fw_mask [NUM_CTX];
  logic [CTXW-1:0]    sel;
  logic               active;
  logic [DW-1:0]      merged;
  logic [NB-1:0]      ld_mask;

  assign st_stall = full[st_ctx] | busy[st_ctx];

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    assign push[c]       = st_valid & (st_ctx == CTXW'(c)) & ~full[c] & ~busy[c];
    assign clr[c]        = dis_valid & (dis_ctx == CTXW'(c)) & ~busy[c];
    assign commit_hit[c] = cmt_valid & (cmt_ctx == CTXW'(c));
    assign pop[c]        = mem_wr_valid & mem_wr_ready & (sel == CTXW'(c));

    ssb_ctx_buf #(
      .DEPTH(DEPTH), .AW(AW), .DW(DW)
    ) u_buf (
      .clk       (clk),
      .rst       (rst),
      .push      (push[c]),
      .push_addr (st_addr),
      .push_data (st_data),
      .push_be   (st_be),
      .pop       (pop[c]),
      .clr       (clr[c]),
      .q_addr    (ld_addr),
      .fwd_data  (fw_data[c]),
      .fwd_mask  (fw_mask[c]),
      .head_addr (hd_addr[c]),
      .head_data (hd_data[c]),
      .head_be   (hd_be[c]),
      .full      (full[c]),
      .empty     (empty[c]),
      .single    (single[c])
    );
  end

  ssb_drain_ctl #(.NUM_CTX(NUM_CTX)) u_drain (
    .clk        (clk),
    .rst        (rst),
    .commit_hit (commit_hit),
    .empty      (empty),
    .single     (single),
    .pop        (pop),
    .busy       (busy),
    .sel        (sel),
    .active     (active)
  );

  assign mem_wr_valid = active & ~empty[sel];
  assign mem_wr_addr  = hd_addr[sel];
  assign mem_wr_data  = hd_data[sel];
  assign mem_wr_be    = hd_be[sel];

  assign ld_mask     = fw_mask[ld_ctx];
  assign mem_rd_en   = ld_valid & ~(&ld_mask);
  assign mem_rd_addr = ld_addr;

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      merged[b*BYTE_W +: BYTE_W] = ld_mask[b] ? fw_data[ld_ctx][b*BYTE_W +: BYTE_W]
                                              : mem_rd_data[b*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_rsp_valid <= 1'b0;
      ld_rsp_data  <= '0;
    end else begin
      ld_rsp_valid <= ld_valid;
      if (ld_valid) ld_rsp_data <= merged;
    end
  end
endmodule

// File: rtl/ssb_checker.sv
module ssb_checker #(
  parameter int unsigned NUM_CTX = 2,
  parameter int unsigned AW      = 32,
  parameter int unsigned DW      = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_CTX-1:0] busy,
  input logic               mem_wr_valid,
  input logic               mem_wr_ready,
  input logic [AW-1:0]      mem_wr_addr,
  input logic [DW-1:0]      mem_wr_data,
  input logic [DW/8-1:0]    mem_wr_be,
  input logic               ld_valid,
  input logic               ld_rsp_valid,
  input logic               mem_rd_en
);
  p_wr_needs_commit_r1: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> (busy != '0));

  p_wr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data) && $stable(mem_wr_be)));

  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> ld_rsp_valid);

  p_rsp_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !ld_valid |=> !ld_rsp_valid);

  p_rd_for_load_r4: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> ld_valid);

  p_reset_idle_r10: assert property (@(posedge clk)
    rst |=> (busy == '0 && !mem_wr_valid && !ld_rsp_valid));
endmodule

bind spec_store_buf ssb_checker #(
  .NUM_CTX(NUM_CTX), .AW(AW), .DW(DW)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .busy         (busy),
  .mem_wr_valid (mem_wr_valid),
  .mem_wr_ready (mem_wr_ready),
  .mem_wr_addr  (mem_wr_addr),
  .mem_wr_data  (mem_wr_data),
  .mem_wr_be    (mem_wr_be),
  .ld_valid     (ld_valid),
  .ld_rsp_valid (ld_rsp_valid),
  .mem_rd_en    (mem_rd_en)
);

// File: tb/sim_spec_store_buf.sv
`timescale 1ns/1ps
module sim_spec_store_buf;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        st_valid = 0, ld_valid = 0, cmt_valid = 0, dis_valid = 0;
  logic [0:0]  st_ctx = 0, ld_ctx = 0, cmt_ctx = 0, dis_ctx = 0;
  logic [31:0] st_addr = 0, st_data = 0, ld_addr = 0;
  logic [3:0]  st_be = 0;
  logic        st_stall, ld_rsp_valid, mem_wr_valid, mem_rd_en;
  logic        mem_wr_ready = 0;
  logic [31:0] ld_rsp_data, mem_wr_addr, mem_wr_data, mem_rd_addr, mem_rd_data;
  logic [3:0]  mem_wr_be;
  logic [1:0]  busy;

  spec_store_buf u0 (.*);

  // Memory model and write log
  logic [31:0] mem [16];
  logic [31:0] exp_mem [16];
  logic [31:0] log_addr [64];
  int          log_n = 0;
  int          cyc = 0;
  bit          rdy_en = 0;
  assign mem_rd_data = mem[mem_rd_addr[5:2]];

  function automatic logic [31:0] init_word(int w);
    return 32'hC0DE0000 ^ (32'h01030507 * w);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      for (int w = 0; w < 16; w++) mem[w] <= init_word(w);
    end else if (mem_wr_valid && mem_wr_ready) begin
      for (int b = 0; b < 4; b++)
        if (mem_wr_be[b]) mem[mem_wr_addr[5:2]][b*8 +: 8] <= mem_wr_data[b*8 +: 8];
      log_addr[log_n] <= mem_wr_addr;
      log_n <= log_n + 1;
    end
  end

  always @(negedge clk) mem_wr_ready <= rdy_en && (cyc % 3 != 2);

  // Bench model of buffered stores
  logic [31:0] m_addr [2][8];
  logic [31:0] m_data [2][8];
  logic [3:0]  m_be   [2][8];
  int          m_cnt  [2];
  int n_chk = 0, n_fail = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] exp_ld(int c, int w);
    logic [31:0] d = mem[w];
    logic [3:0]  m = 0;
    for (int i = 0; i < m_cnt[c]; i++)
      if (m_addr[c][i] == 32'(w * 4))
        for (int b = 0; b < 4; b++)
          if (m_be[c][i][b]) begin d[b*8 +: 8] = m_data[c][i][b*8 +: 8]; m[b] = 1; end
    return {m, d};
  endfunction

  task automatic store(int c, logic [31:0] a, logic [31:0] d, logic [3:0] be);
    st_valid = 1; st_ctx = 1'(c); st_addr = a; st_data = d; st_be = be;
    @(negedge clk);
    st_valid = 0;
    if (m_cnt[c] < 8) begin
      m_addr[c][m_cnt[c]] = a; m_data[c][m_cnt[c]] = d; m_be[c][m_cnt[c]] = be;
      m_cnt[c]++;
    end
  endtask

  task automatic load_chk(int c, int w, string req);
    logic [35:0] e;
    ld_valid = 1; ld_ctx = 1'(c); ld_addr = 32'(w * 4);
    #1;
    e = exp_ld(c, w);
    chk(mem_rd_en == (e[35:32] != 4'hF), {req, " rd_en"}, 32'(mem_rd_en), 32'(e[35:32] != 4'hF));
    @(negedge clk);
    ld_valid = 0;
    chk(ld_rsp_valid && ld_rsp_data == e[31:0], {req, " data"}, ld_rsp_data, e[31:0]);
  endtask

  task automatic apply_model(int c);
    for (int i = 0; i < m_cnt[c]; i++)
      for (int b = 0; b < 4; b++)
        if (m_be[c][i][b]) exp_mem[m_addr[c][i][5:2]][b*8 +: 8] = m_data[c][i][b*8 +: 8];
  endtask

  task automatic commit(int c);
    cmt_valid = 1; cmt_ctx = 1'(c);
    @(negedge clk);
    cmt_valid = 0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 200 && busy != 0; k++) @(negedge clk);
  endtask

  task automatic mem_chk(string req);
    for (int w = 0; w < 8; w++) chk(mem[w] == exp_mem[w], req, mem[w], exp_mem[w]);
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int base, n;
    m_cnt[0] = 0; m_cnt[1] = 0;
    for (int w = 0; w < 16; w++) exp_mem[w] = init_word(w);
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10: idle after reset
    chk(busy == 0, "R10 busy", 32'(busy), 0);
    chk(!mem_wr_valid, "R10 wr_valid", 32'(mem_wr_valid), 0);
    chk(!st_stall, "R10 stall", 32'(st_stall), 0);
    chk(!ld_rsp_valid, "R10 rsp", 32'(ld_rsp_valid), 0);
    load_chk(0, 3, "R10 empty buffer load");

    // Fill both contexts with overlapping stores of assorted byte enables
    for (int i = 0; i < 8; i++)
      for (int c = 0; c < 2; c++)
        store(c, 32'(((i * 3 + c) % 5) * 4), 32'hA5000000 + 32'(c * 256 + i * 17) * 32'h00010101,
              4'(i * 5 + c + 1));
    // R2/R3/R4: sweep loads on every word for both contexts
    for (int c = 0; c < 2; c++)
      for (int w = 0; w < 8; w++) load_chk(c, w, "R2 R3 R4 sweep");
    chk(!mem_wr_valid && log_n == 0, "R1 no write before commit", 32'(log_n), 0);

    // R8: full buffer stalls and the rejected store leaves no trace
    st_ctx = 0; #1;
    chk(st_stall, "R8 full stall", 32'(st_stall), 1);
    store(0, 32'd28, 32'hDEADBEEF, 4'hF);
    load_chk(0, 7, "R8 rejected store");

    // R7: discard context 1
    dis_valid = 1; dis_ctx = 1; @(negedge clk); dis_valid = 0; m_cnt[1] = 0;
    repeat (3) @(negedge clk);
    chk(log_n == 0 && busy == 0, "R7 no write on discard", 32'(log_n), 0);
    for (int w = 0; w < 5; w++) load_chk(1, w, "R7 discarded loads");

    // R5/R6: commit context 0 with a gappy ready
    rdy_en = 1;
    commit(0);
    chk(busy[0], "R6 busy after commit", 32'(busy), 1);
    st_ctx = 0; #1;
    chk(st_stall, "R6 stall while busy", 32'(st_stall), 1);
    wait_idle();
    chk(log_n == 8, "R5 drain count", 32'(log_n), 8);
    for (int i = 0; i < 8; i++)
      chk(log_addr[i] == m_addr[0][i], "R5 program order", log_addr[i], m_addr[0][i]);
    apply_model(0); m_cnt[0] = 0;
    mem_chk("R5 memory after drain");
    for (int w = 0; w < 5; w++) load_chk(0, w, "R5 loads after drain");

    // R9: discard while draining is ignored
    base = log_n;
    for (int i = 0; i < 3; i++) store(1, 32'(i * 8), 32'h5A5A0000 + 32'(i), 4'b0011);
    commit(1);
    dis_valid = 1; dis_ctx = 1; @(negedge clk); dis_valid = 0;
    wait_idle();
    chk(log_n - base == 3, "R9 discard ignored", 32'(log_n - base), 3);
    apply_model(1); m_cnt[1] = 0;
    mem_chk("R9 memory");

    // R11: a drain that started finishes before another
    rdy_en = 0;
    base = log_n;
    for (int i = 0; i < 2; i++) store(1, 32'(20 + i * 4), 32'h11110000 + 32'(i), 4'hF);
    for (int i = 0; i < 2; i++) store(0, 32'(4 + i * 8), 32'h22220000 + 32'(i), 4'b1100);
    commit(1);
    commit(0);
    chk(busy == 2'b11, "R11 both waiting", 32'(busy), 3);
    rdy_en = 1;
    wait_idle();
    n = log_n - base;
    chk(n == 4, "R11 count", 32'(n), 4);
    chk(log_addr[base] == m_addr[1][0] && log_addr[base+1] == m_addr[1][1],
        "R11 first buffer whole", log_addr[base+1], m_addr[1][1]);
    chk(log_addr[base+2] == m_addr[0][0] && log_addr[base+3] == m_addr[0][1],
        "R11 second buffer after", log_addr[base+3], m_addr[0][1]);
    apply_model(1); apply_model(0); m_cnt[0] = 0; m_cnt[1] = 0;
    mem_chk("R11 memory");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule